// File: doc/BRIEF.md
# UART Receive Holding Register with Overrun Control

This block is the receive-side holding stage of a UART. A serial shifter, outside the block, assembles each incoming character. When a character is complete, the shifter pulses a strobe and presents the byte. The block keeps one character in a holding register. It maintains a data-available flag, a lost-character (overrun) flag and a pending DMA request. From these flags and three enable inputs it drives a single interrupt line. Software, or a DMA engine, empties the holding register through bus read strobes.

When a character completes while the previous one is still unread, or while the previous DMA request is still unacknowledged, the new character is thrown away. The held character stays readable, and the overrun flag is raised. While the overrun flag is up, every further character is dropped, even if the holding register has meanwhile been read. The overrun flag can only be cleared by a status read that sees it set, followed later by a data read. Losing another character between those two reads cancels the pending clear.

Top module: `rx_holding_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the holding register to zero, and clears data-available, overrun, the DMA request and the interrupt.
- R2: A byte-complete strobe loads the byte one clock later and sets data-available, provided data-available, overrun and the DMA request are all clear.
- R3: A byte-complete strobe while data-available is set raises overrun one clock later and leaves the holding register unchanged.
- R4: A byte-complete strobe while the DMA request is still pending raises overrun and drops the byte, even when data-available is clear.
- R5: While overrun is set, no byte-complete strobe changes the holding register, whatever the state of data-available.
- R6: A data read clears data-available one clock later. A DMA acknowledge clears both the DMA request and data-available one clock later.
- R7: When a data read and a byte-complete strobe occur in the same cycle while data-available is set, the overrun decision uses the value before the read: overrun becomes 1, data-available becomes 0, and the holding register is unchanged.
- R8: Overrun clears one clock after a data read only if an earlier status read, in a previous cycle, observed overrun set. A data read alone does not clear it, and neither does a status read in the same cycle as the data read.
- R9: A byte dropped between the status read and the data read cancels the pending clear, so the following data read leaves overrun set.
- R10: The interrupt is high when the receive enable is set and either data-available or overrun is set. It is also high when the error enable, the DMA-mode input and overrun are all set. It is low otherwise.
- R11: A byte loaded while the DMA-mode input is high sets the DMA request one clock later. A byte loaded while DMA mode is low leaves the request clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byteDone | input | 1 | One-cycle strobe from the shifter: a character is complete |
| byteIn | input | DATA_W | Character presented with byteDone |
| statusRd | input | 1 | Bus read strobe of the status register |
| dataRd | input | 1 | Bus read strobe of the data register |
| dmaAck | input | 1 | DMA engine has taken the held character |
| rxIntEn | input | 1 | Receive interrupt enable |
| errIntEn | input | 1 | Error interrupt enable |
| dmaRxEn | input | 1 | DMA receive mode |
| rdData | output | DATA_W | Holding register contents |
| dataAvail | output | 1 | Unread character present |
| overrun | output | 1 | At least one character has been lost |
| dmaReq | output | 1 | DMA request pending |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest states to reach are the ones where overrun is set while data-available is clear. The bench gets there in two ways. The first is a data read issued in the same cycle as a byte-complete strobe. The second is a character dropped after the status read and before the data read, which also checks that the pending clear is cancelled. A stimulus table drives these races cycle by cycle, together with a status read and a data read issued in the same cycle. Further DMA-mode rows leave the request unacknowledged while the processor empties the register, to show that a byte is lost with data-available low.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture the incoming character into the holding register
  } ctrlStrobes_t;
endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         byteDone,
  input  logic         statusRd,
  input  logic         dataRd,
  input  logic         dmaAck,
  input  logic         dmaRxEn,
  output ctrlStrobes_t strb,
  output logic         dataAvail,
  output logic         overrun,
  output logic         dmaReq
);
  logic stsSeen;
  logic busy;
  logic lose;
  logic take;
  logic clearOk;

  // busy uses the pre-read flag values, so a read in the same cycle cannot rescue a byte
  assign busy    = dataAvail | dmaReq;
  assign lose    = byteDone & (busy | overrun);
  assign take    = byteDone & ~busy & ~overrun;
  assign clearOk = dataRd & stsSeen & overrun & ~lose;

  assign strb.load = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataAvail <= 1'b0;
      overrun   <= 1'b0;
      dmaReq    <= 1'b0;
      stsSeen   <= 1'b0;
    end else begin
      if (take)                  dataAvail <= 1'b1;
      else if (dataRd || dmaAck) dataAvail <= 1'b0;

      if (lose)         overrun <= 1'b1;
      else if (clearOk) overrun <= 1'b0;

      if (lose || !overrun || clearOk) stsSeen <= 1'b0;
      else if (statusRd)               stsSeen <= 1'b1;

      if (take && dmaRxEn) dmaReq <= 1'b1;
      else if (dmaAck)     dmaReq <= 1'b0;
    end
  end

  // R2
  load_sets_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (byteDone && !dataAvail && !overrun && !dmaReq) |=> dataAvail);

  // R3
  busy_byte_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (byteDone && dataAvail) |=> overrun);

  // R6
  read_clears_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (dataRd && !byteDone) |=> !dataAvail);

  // R8
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && !dataRd) |=> overrun);

  // R11
  dma_req_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (byteDone && !dataAvail && !overrun && !dmaReq && dmaRxEn) |=> dmaReq);
endmodule

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] byteIn,
  output logic [DATA_W-1:0] holdReg
);
  always_ff @(posedge clk) begin
    if (rst)            holdReg <= '0;
    else if (strb.load) holdReg <= byteIn;
  end
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq (
  input  logic rxIntEn,
  input  logic errIntEn,
  input  logic dmaRxEn,
  input  logic dataAvail,
  input  logic overrun,
  output logic irq
);
  logic rxCause;
  logic errCause;

  assign rxCause  = rxIntEn & (dataAvail | overrun);
  assign errCause = errIntEn & dmaRxEn & overrun;
  assign irq      = rxCause | errCause;
endmodule

// File: rtl/rx_holding_ctrl.sv
module rx_holding_ctrl
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              statusRd,
  input  logic              dataRd,
  input  logic              dmaAck,
  input  logic              rxIntEn,
  input  logic              errIntEn,
  input  logic              dmaRxEn,
  output logic [DATA_W-1:0] rdData,
  output logic              dataAvail,
  output logic              overrun,
  output logic              dmaReq,
  output logic              irq
);
  ctrlStrobes_t strb;

  rxbuf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .byteDone(byteDone), .statusRd(statusRd),
    .dataRd(dataRd), .dmaAck(dmaAck), .dmaRxEn(dmaRxEn), .strb(strb),
    .dataAvail(dataAvail), .overrun(overrun), .dmaReq(dmaReq)
  );

  rxbuf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .byteIn(byteIn), .holdReg(rdData)
  );

  rxbuf_irq u_irq (
    .rxIntEn(rxIntEn), .errIntEn(errIntEn), .dmaRxEn(dmaRxEn),
    .dataAvail(dataAvail), .overrun(overrun), .irq(irq)
  );

  // R5
  overrun_holds_data_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && byteDone) |=> $stable(rdData));

  // R4
  pending_dma_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (byteDone && dmaReq) |=> (overrun && $stable(rdData)));
endmodule

// File: tb/rx_holding_ctrl_test.sv
module rx_holding_ctrl_test;
  typedef struct packed {
    logic       bd;
    logic [7:0] b;
    logic       sr;
    logic       dr;
    logic       ack;
    logic       dma;
    logic [7:0] eData;
    logic       eAvail;
    logic       eOvr;
    logic       eReq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0, 1'b0}, // R2 load
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0, 1'b0}, // idle
    '{1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b1, 1'b0}, // R3
    '{1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b1, 1'b0}, // R5
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1, 1'b0, 1'b1, 1'b0}, // R6 / R8 read alone
    '{1'b1, 8'hD4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b0, 1'b1, 1'b0}, // R5 avail low
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b0, 1'b1, 1'b0}, // status read
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0}, // R8 cleared
    '{1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0}, // R2
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0}, // status, no overrun
    '{1'b1, 8'h66, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0}, // R7 race
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0}, // status
    '{1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0}, // R9 drop in between
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0}, // R9 not cleared
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0}, // status again
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0}, // R8 cleared
    '{1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 1'b1, 8'h88, 1'b1, 1'b0, 1'b1}, // R11 request
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h88, 1'b0, 1'b0, 1'b1}, // cpu read, req stays
    '{1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 1'b1, 8'h88, 1'b0, 1'b1, 1'b1}, // R4
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h88, 1'b0, 1'b1, 1'b0}, // R6 ack
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h88, 1'b0, 1'b1, 1'b0}, // status
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h88, 1'b0, 1'b0, 1'b0}, // R8 cleared
    '{1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1}, // R11
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0}, // R6 ack clears avail
    '{1'b1, 8'h4D, 1'b0, 1'b0, 1'b0, 1'b0, 8'h4D, 1'b1, 1'b0, 1'b0}, // R11 no request
    '{1'b1, 8'h5E, 1'b0, 1'b0, 1'b0, 1'b0, 8'h4D, 1'b1, 1'b1, 1'b0}, // R3
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h4D, 1'b0, 1'b1, 1'b0}, // R8 same-cycle pair
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h4D, 1'b0, 1'b0, 1'b0}  // R8 later read clears
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byteDone = 1'b0;
  logic [7:0] byteIn = '0;
  logic       statusRd = 1'b0;
  logic       dataRd = 1'b0;
  logic       dmaAck = 1'b0;
  logic       rxIntEn = 1'b0;
  logic       errIntEn = 1'b0;
  logic       dmaRxEn = 1'b0;
  logic [7:0] rdData;
  logic       dataAvail;
  logic       overrun;
  logic       dmaReq;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_holding_ctrl #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .byteDone(byteDone), .byteIn(byteIn),
    .statusRd(statusRd), .dataRd(dataRd), .dmaAck(dmaAck),
    .rxIntEn(rxIntEn), .errIntEn(errIntEn), .dmaRxEn(dmaRxEn),
    .rdData(rdData), .dataAvail(dataAvail), .overrun(overrun),
    .dmaReq(dmaReq), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    byteDone = 1'b0; byteIn = '0; statusRd = 1'b0; dataRd = 1'b0; dmaAck = 1'b0;
  endtask

  initial begin
    idleIn();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 data", rdData, 0);
    chk("R1 avail", dataAvail, 0);
    chk("R1 ovr", overrun, 0);
    chk("R1 req", dmaReq, 0);
    chk("R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      byteDone = VECS[i].bd;  byteIn = VECS[i].b;
      statusRd = VECS[i].sr;  dataRd = VECS[i].dr;
      dmaAck   = VECS[i].ack; dmaRxEn = VECS[i].dma;
      @(negedge clk);
      chk($sformatf("R2-table row %0d data", i), rdData, VECS[i].eData);
      chk($sformatf("R6-table row %0d avail", i), dataAvail, VECS[i].eAvail);
      chk($sformatf("R8-table row %0d ovr", i), overrun, VECS[i].eOvr);
      chk($sformatf("R11-table row %0d req", i), dmaReq, VECS[i].eReq);
    end
    idleIn(); dmaRxEn = 1'b0;

    // R10 interrupt combinations
    rxIntEn = 1'b1; #1;
    chk("R10 rx en, nothing pending", irq, 0);
    byteDone = 1'b1; byteIn = 8'h11; @(negedge clk); idleIn(); #1;
    chk("R10 rx en, data avail", irq, 1);
    rxIntEn = 1'b0; #1;
    chk("R10 no enable", irq, 0);
    byteDone = 1'b1; byteIn = 8'h22; @(negedge clk); idleIn();
    dataRd = 1'b1; @(negedge clk); idleIn(); #1;
    chk("R10 ovr with avail low", {dataAvail, overrun}, 2'b01);
    errIntEn = 1'b1; #1;
    chk("R10 err en without dma mode", irq, 0);
    dmaRxEn = 1'b1; #1;
    chk("R10 err en with dma mode", irq, 1);
    errIntEn = 1'b0; rxIntEn = 1'b1; dmaRxEn = 1'b0; #1;
    chk("R10 rx en on overrun", irq, 1);
    chk("R5 data kept", rdData, 8'h11);

    // R1 reset from a busy state
    byteDone = 1'b1; byteIn = 8'h33; @(negedge clk); idleIn();
    rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
    chk("R1 data after reset", rdData, 0);
    chk("R1 flags after reset", {dataAvail, overrun, dmaReq}, 3'b000);
    chk("R1 irq after reset", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule